// File: doc/BRIEF.md
# Late-Write Pipelined SRAM Core

This block is a synchronous single-port memory with a one-cycle registered read path and a deferred ("late") write path. A command is taken on a rising clock edge when the active-low select is low. A read command returns its word from the output register on the next rising edge. A write command supplies only its address and byte enables on that edge. Its data follows on the next edge and is then held in a write buffer. The buffered word enters the array only when a later write reaches its own data cycle. Any number of read or idle cycles may pass before that happens.

A read of the buffered address still returns the newest data. Each byte that the buffered write enabled is taken from the buffer, and the remaining bytes come from the array, with no added latency. An asynchronous sleep input makes the block ignore every other input and turns the data output off, and the stored contents are kept. The array is a behavioural register file whose word is a parameterised number of 9-bit bytes.

Top module: `lwsram_core`

## Requirements
- R1: A read command (`sel_n`=0, `we_n`=1) taken on clock edge N places the addressed word on `dout` and raises `dout_vld` after edge N+1, when output is enabled.
- R2: A write command (`sel_n`=0, `we_n`=0) takes its address and byte enables on edge N and its data from `din` on edge N+1.
- R3: A cycle with `sel_n`=1 is a deselect. It reads nothing, writes nothing, leaves the write buffer unchanged, and gives `dout_vld`=0 one cycle later.
- R4: A buffered write enters the array only at the data edge of the next write. Reads and deselects in between leave the buffer and array untouched.
- R5: `be_n[i]`=0 enables byte i, which is `din[9*i+8:9*i]`. Disabled bytes keep their previous array value when the write is committed.
- R6: A read of the buffered address returns the buffer's byte for every byte the buffered write enabled and the array's byte otherwise, with the same latency as R1.
- R7: Back-to-back reads of one address give the same `dout` value in each cycle. The output register changes only when a read completes.
- R8: While `sleep` is 1, every other input is ignored (no command is taken, no write data is captured), `dout_vld` is 0 and `dout` is high-impedance. Memory contents survive.
- R9: `oe_n` is taken with the read command. If it is 1, that read's result cycle shows `dout_vld`=0 and `dout` high-impedance. Write and deselect result cycles also show `dout_vld`=0.
- R10: Reset empties the write buffer. A read after reset returns array contents even at the address that was buffered before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Asynchronous low-power request, active high |
| sel_n | input | 1 | Command select, active low |
| we_n | input | 1 | Write command when low, read when high |
| be_n | input | BYTES | Per-byte write enables, active low |
| oe_n | input | 1 | Output enable for the read issued in this cycle, active low |
| addr | input | ADDR_W | Word address |
| din | input | BYTES*9 | Write data, one cycle after its write command |
| dout | output | BYTES*9 | Read data, high-impedance when not valid |
| dout_vld | output | 1 | High when `dout` carries read data |

## Verification
The bench aims at the window in which a word exists only in the write buffer. It reads that word as a whole and after a partial-byte write, so a design that ignored the buffer would return stale array data, and one that merged whole words would clobber bytes that were never enabled. It places a reset while a write is still buffered. A design that committed writes early, or that kept the buffer across reset, would then return the newer word. Repeated reads of one address, writes issued with select high or during sleep, and a read issued with output disabled check that the output stays steady and that ignored stimulus leaves the memory unchanged.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;
    localparam int BYTE_W = 9;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/lwsram_ctrl.sv
module lwsram_ctrl
    import lwsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              sel_n,
    input  logic              we_n,
    input  logic [BYTES-1:0]  be_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output op_e               op,
    output logic [ADDR_W-1:0] op_addr,
    output logic [BYTES-1:0]  op_be,
    output logic              op_drive
);
    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [BYTES-1:0]  be;
        logic              drive;
    } cmd_t;

    cmd_t cmd_d, cmd_q;

    always_comb begin
        cmd_d       = cmd_q;
        cmd_d.op    = OP_NONE;
        cmd_d.drive = 1'b0;
        if (!sleep && !sel_n) begin
            cmd_d.addr  = addr;
            cmd_d.be    = ~be_n;
            if (we_n) begin
                cmd_d.op    = OP_READ;
                cmd_d.drive = ~oe_n;
            end else begin
                cmd_d.op    = OP_WRITE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign op       = cmd_q.op;
    assign op_addr  = cmd_q.addr;
    assign op_be    = cmd_q.be;
    assign op_drive = cmd_q.drive;

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> (op == OP_NONE)); // R3
    AST_SLEEP_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (op == OP_NONE)); // R8
endmodule

// File: rtl/lwsram_wbuf.sv
module lwsram_wbuf
    import lwsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sleep,
    input  logic                      stage_vld,
    input  logic [ADDR_W-1:0]         stage_addr,
    input  logic [BYTES-1:0]          stage_be,
    input  logic [BYTES*BYTE_W-1:0]   din,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic                      commit_en,
    output logic [ADDR_W-1:0]         commit_addr,
    output logic [BYTES-1:0]          commit_be,
    output logic [BYTES*BYTE_W-1:0]   commit_data,
    output logic [BYTES-1:0]          hit_be
);
    localparam int WORD_W = BYTES * BYTE_W;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [BYTES-1:0]  be;
        logic [WORD_W-1:0] data;
    } wbuf_t;

    wbuf_t buf_d, buf_q;
    logic  load;

    always_comb begin
        load  = stage_vld && !sleep;
        buf_d = buf_q;
        if (load) begin
            buf_d.vld  = 1'b1;
            buf_d.addr = stage_addr;
            buf_d.be   = stage_be;
            buf_d.data = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign commit_en   = load && buf_q.vld;
    assign commit_addr = buf_q.addr;
    assign commit_be   = buf_q.be;
    assign commit_data = buf_q.data;
    assign hit_be      = (buf_q.vld && buf_q.addr == rd_addr) ? buf_q.be : '0;

    AST_BUF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !stage_vld |=> $stable(buf_q)); // R4
endmodule

// File: rtl/lwsram_array.sv
module lwsram_array
    import lwsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 4
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [BYTES-1:0]        wbe,
    input  logic [BYTES*BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [BYTES*BYTE_W-1:0] rdata
);
    localparam int WORD_W = BYTES * BYTE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] old_word;
    logic [WORD_W-1:0] new_word;

    assign old_word = mem[waddr];

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign new_word[b*BYTE_W +: BYTE_W] = wbe[b] ? wdata[b*BYTE_W +: BYTE_W]
                                                     : old_word[b*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= new_word;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/lwsram_core.sv
module lwsram_core
    import lwsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 4,
    localparam int WORD_W = BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              sel_n,
    input  logic              we_n,
    input  logic [BYTES-1:0]  be_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              dout_vld
);
    typedef struct packed {
        logic              vld;
        logic              drive;
        logic [WORD_W-1:0] data;
    } out_t;

    op_e               op;
    logic [ADDR_W-1:0] op_addr;
    logic [BYTES-1:0]  op_be;
    logic              op_drive;
    logic              commit_en;
    logic [ADDR_W-1:0] commit_addr;
    logic [BYTES-1:0]  commit_be;
    logic [WORD_W-1:0] commit_data;
    logic [BYTES-1:0]  hit_be;
    logic [WORD_W-1:0] arr_word;
    logic [WORD_W-1:0] merged;
    out_t              out_d, out_q;

    lwsram_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep    (sleep),
        .sel_n    (sel_n),
        .we_n     (we_n),
        .be_n     (be_n),
        .oe_n     (oe_n),
        .addr     (addr),
        .op       (op),
        .op_addr  (op_addr),
        .op_be    (op_be),
        .op_drive (op_drive)
    );

    lwsram_wbuf #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_wbuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep       (sleep),
        .stage_vld   (op == OP_WRITE),
        .stage_addr  (op_addr),
        .stage_be    (op_be),
        .din         (din),
        .rd_addr     (op_addr),
        .commit_en   (commit_en),
        .commit_addr (commit_addr),
        .commit_be   (commit_be),
        .commit_data (commit_data),
        .hit_be      (hit_be)
    );

    lwsram_array #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_array (
        .clk   (clk),
        .we    (commit_en),
        .waddr (commit_addr),
        .wbe   (commit_be),
        .wdata (commit_data),
        .raddr (op_addr),
        .rdata (arr_word)
    );

    for (genvar b = 0; b < BYTES; b++) begin : g_merge
        assign merged[b*BYTE_W +: BYTE_W] = hit_be[b] ? commit_data[b*BYTE_W +: BYTE_W]
                                                      : arr_word[b*BYTE_W +: BYTE_W];
    end

    always_comb begin
        out_d       = out_q;
        out_d.vld   = 1'b0;
        out_d.drive = 1'b0;
        if (op == OP_READ) begin
            out_d.vld   = 1'b1;
            out_d.drive = op_drive;
            out_d.data  = merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dout_vld = out_q.vld && out_q.drive && !sleep;
    assign dout     = dout_vld ? out_q.data : {WORD_W{1'bz}};

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_READ) |=> out_q.vld); // R1
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_READ) |=> $stable(out_q.data)); // R7
    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dout_vld); // R8
    AST_WRITE_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE) |=> !dout_vld); // R9
endmodule

// File: tb/sim_lwsram_core.sv
module sim_lwsram_core;
    localparam int ADDR_W = 8;
    localparam int BYTES  = 4;
    localparam int BW     = 9;
    localparam int W      = BYTES * BW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sleep = 1'b0;
    logic              sel_n = 1'b1;
    logic              we_n = 1'b1;
    logic [BYTES-1:0]  be_n = '1;
    logic              oe_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [W-1:0]      din = '0;
    logic [W-1:0]      dout;
    logic              dout_vld;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lwsram_core #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u0 (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel_n(sel_n), .we_n(we_n),
        .be_n(be_n), .oe_n(oe_n), .addr(addr), .din(din),
        .dout(dout), .dout_vld(dout_vld)
    );

    typedef struct packed {
        int         due;
        logic       vld;
        logic [W-1:0] data;
        int         req;
    } exp_t;
    exp_t exq[$];

    // Reference model built from the requirements
    logic [W-1:0]      mdl_mem [int];
    logic              mb_vld = 1'b0;
    logic [ADDR_W-1:0] mb_addr = '0;
    logic [BYTES-1:0]  mb_be = '0;
    logic [W-1:0]      mb_data = '0;
    logic              pw_vld = 1'b0;
    logic [ADDR_W-1:0] pw_addr = '0;
    logic [BYTES-1:0]  pw_be = '0;

    function automatic logic [W-1:0] mem_rd(input logic [ADDR_W-1:0] a);
        if (mdl_mem.exists(int'(a))) return mdl_mem[int'(a)];
        return '0;
    endfunction

    function automatic logic [W-1:0] lane_mix(input logic [W-1:0] base,
                                              input logic [W-1:0] upd,
                                              input logic [BYTES-1:0] en);
        logic [W-1:0] r = base;
        for (int b = 0; b < BYTES; b++)
            if (en[b]) r[b*BW +: BW] = upd[b*BW +: BW];
        return r;
    endfunction

    task automatic check(input bit ok, input int req, input logic [W-1:0] act,
                         input logic [W-1:0] expv, input logic av, input logic ev);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d cyc=%0d actual vld=%0b data=%h expected vld=%0b data=%h",
                     req, cyc, av, act, ev, expv);
        end
    endtask

    // One bus cycle: command fields plus din for the previous write's data phase
    task automatic step(input bit s_n, input bit w_n, input logic [BYTES-1:0] ben,
                        input logic [ADDR_W-1:0] a, input bit o_n,
                        input logic [W-1:0] wd, input int req);
        exp_t e;
        bit is_rd;
        bit is_wr;
        @(negedge clk);
        sel_n = s_n; we_n = w_n; be_n = ben; addr = a; oe_n = o_n; din = wd;
        if (pw_vld && !sleep) begin
            if (mb_vld) mdl_mem[int'(mb_addr)] = lane_mix(mem_rd(mb_addr), mb_data, mb_be);
            mb_vld = 1'b1; mb_addr = pw_addr; mb_be = pw_be; mb_data = wd;
        end
        is_rd = !sleep && !s_n && w_n;
        is_wr = !sleep && !s_n && !w_n;
        pw_vld = is_wr; pw_addr = a; pw_be = ~ben;
        e.due  = cyc + 2;
        e.vld  = is_rd && !o_n;
        e.data = mem_rd(a);
        if (mb_vld && mb_addr == a) e.data = lane_mix(e.data, mb_data, mb_be);
        e.req  = req;
        exq.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b1, '1, '0, 1'b0, '0, 3);
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input int req);
        step(1'b0, 1'b1, '1, a, 1'b0, '0, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sel_n = 1'b1;
        mb_vld = 1'b0; pw_vld = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: compares each scoreboard entry in its result cycle
    initial begin
        exp_t e;
        logic ev;
        forever begin
            @(negedge clk);
            #1;
            if (exq.size() > 0 && exq[0].due == cyc) begin
                e  = exq.pop_front();
                ev = e.vld && !sleep;   // R8: sleep forces the output off
                if (ev)
                    check(dout_vld === 1'b1 && dout === e.data, e.req, dout, e.data, dout_vld, ev);
                else
                    check(dout_vld === 1'b0, e.req, dout, e.data, dout_vld, ev);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL R1 watchdog expired actual=hung expected=finished");
        finish_run();
    end

    localparam logic [W-1:0] D1 = 36'h1_2345_6789;
    localparam logic [W-1:0] D2 = 36'hA_BCDE_F012;
    localparam logic [W-1:0] P1 = 36'h5_5555_5555;
    localparam logic [W-1:0] D4 = 36'h9_0F0F_0F0F;
    localparam logic [W-1:0] D5 = 36'h3_1111_2222;
    localparam logic [W-1:0] D6 = 36'h6_3333_4444;
    localparam logic [W-1:0] D7 = 36'hC_5555_6666;
    localparam logic [W-1:0] D9 = 36'hF_FFFF_FFFF;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(dout_vld === 1'b0, 10, dout, '0, dout_vld, 1'b0); // R10 reset state

        // R2: write 10 then 11; R1: read 10 from array; R6: read 11 from buffer
        step(1'b0, 1'b0, 4'b0000, 8'd10, 1'b0, '0, 2);
        step(1'b0, 1'b0, 4'b0000, 8'd11, 1'b0, D1, 2);
        step(1'b0, 1'b1, '1, 8'd10, 1'b0, D2, 1);
        rd(8'd11, 6);
        idle(1);

        // R6: partial write of bytes 0 and 2 at 10, merged with array bytes
        step(1'b0, 1'b0, 4'b1010, 8'd10, 1'b0, '0, 5);
        step(1'b0, 1'b1, '1, 8'd10, 1'b0, P1, 6);
        // R7: back-to-back reads of the same address stay steady
        rd(8'd10, 7);
        rd(8'd10, 7);
        rd(8'd11, 4);
        idle(1);

        // R3: write with select high is ignored
        step(1'b1, 1'b0, 4'b0000, 8'd11, 1'b0, '0, 3);
        step(1'b1, 1'b1, '1, 8'd11, 1'b0, D9, 3);
        rd(8'd11, 3);
        // R9: read with output disabled, then a write result cycle
        step(1'b0, 1'b1, '1, 8'd11, 1'b1, '0, 9);
        // R5: full write 20 commits the partial word at 10
        step(1'b0, 1'b0, 4'b0000, 8'd20, 1'b0, '0, 9);
        step(1'b0, 1'b1, '1, 8'd10, 1'b0, D4, 5);
        rd(8'd20, 6);
        idle(2);

        // R8: commands during sleep are ignored and output stays off
        @(negedge clk);
        sleep = 1'b1;
        step(1'b0, 1'b0, 4'b0000, 8'd11, 1'b0, '0, 8);
        step(1'b0, 1'b1, '1, 8'd11, 1'b0, D9, 8);
        idle(2);
        @(negedge clk);
        sleep = 1'b0;
        idle(1);
        rd(8'd11, 8);
        rd(8'd20, 8);
        idle(1);

        // R4 and R10: a buffered write does not survive reset
        step(1'b0, 1'b0, 4'b0000, 8'd30, 1'b0, '0, 2);
        step(1'b0, 1'b0, 4'b0000, 8'd31, 1'b0, D5, 2);
        step(1'b0, 1'b0, 4'b0000, 8'd30, 1'b0, D6, 4);
        step(1'b0, 1'b1, '1, 8'd30, 1'b0, D7, 6);
        rd(8'd10, 4);
        rd(8'd20, 4);
        rd(8'd30, 4);
        idle(3);
        do_reset();
        @(negedge clk);
        #1;
        check(dout_vld === 1'b0, 10, dout, '0, dout_vld, 1'b0); // R10
        rd(8'd30, 10);
        rd(8'd31, 10);
        rd(8'd20, 10);
        idle(4);
        finish_run();
    end
endmodule